// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Recency Bit

This block is a small read cache that sits between a requester and a slower backing memory. Storage is one-word blocks arranged as `SETS` sets of two ways. Each way has a valid flag, a tag and a data word, and each set has one recency bit. A request carries a block address. The low bits select a set, and both ways of that set are compared against the upper bits at the same time. A matching way drives the returned word through an AND-OR multiplexer.

When neither way matches, the block fetches the word from the backing memory over a simple request and acknowledge pair and writes it into a victim way. If a way of the set is still empty, that way is the victim; otherwise the recency bit picks it. The recency bit is rewritten on every hit and every fill so that it names the way that was not just used. Each access returns exactly one response pulse, flagged as a hit or a miss, so that the requester can count misses.

Top module: `cache2w_lru`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `mem_req` are 0, and every way of every set is empty, so the first access to any block is a miss.
- R2: The set index is the low `$clog2(SETS)` bits of the block address and the tag is the remaining upper bits. Blocks whose low bits differ never displace one another.
- R3: On a hit, `resp_valid` and `resp_hit` are high in the cycle after the request is accepted, `resp_data` holds the stored word, and `mem_req` stays low.
- R4: On a miss, `mem_req` rises in the cycle after acceptance with `mem_blk` equal to the requested block address, and both hold until `mem_ack`. The response, with `resp_miss` high and `resp_data` equal to `mem_rdata`, appears in the cycle after the acknowledge edge.
- R5: Both ways of a set are searched at once, so two blocks with the same index and different tags can be resident together and both hit.
- R6: An empty way of the indexed set is filled before any valid way is evicted.
- R7: When both ways are valid, a miss evicts the way not referenced most recently. Hits and fills both update that recency.
- R8: With two sets, the block sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss. Block 6 evicts block 8 and the last access to 8 evicts block 0, so a following 6 hits and a following 0 misses.
- R9: `resp_valid` is a one-cycle pulse with exactly one of `resp_hit` and `resp_miss` high. `req_ready` is low from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| req_blk | input | ADDR_W | Requested block address |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response was a hit |
| resp_miss | output | 1 | Response was a miss |
| resp_data | output | DATA_W | Returned word |
| mem_req | output | 1 | Fetch request to backing memory |
| mem_blk | output | ADDR_W | Block address of the fetch |
| mem_ack | input | 1 | Backing memory returns the word this cycle |
| mem_rdata | input | DATA_W | Word from backing memory |

## Verification
A hit response is due one clock after the accepting edge. A miss raises `mem_req` one clock after acceptance and responds one clock after the acknowledge edge. With the bench memory answering after `MEM_LAT` observed cycles, the miss latency is `MEM_LAT + 2` cycles. The bench counts falling edges from the accepting edge until `resp_valid` and compares that count, the hit or miss flag and the word with a reference model of the sets that it keeps itself. The memory model checks `mem_blk` at every acknowledge, and any `mem_req` seen during a hit access is reported.

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_blk,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_blk,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL} st_t;
  st_t state;

  logic [ADDR_W-1:0] cur;
  logic [1:0]        vld  [SETS];
  logic [TAG_W-1:0]  tagm [SETS][2];
  logic [DATA_W-1:0] dat  [SETS][2];
  logic [SETS-1:0]   lru;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [1:0]       way_hit;
  logic             hit, victim, fill;
  logic [DATA_W-1:0] hit_data;

  assign idx = cur[IDX_W-1:0];
  assign tag = cur[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = vld[idx][w] && (tagm[idx][w] == tag);
  end

  assign hit      = |way_hit;
  assign hit_data = ({DATA_W{way_hit[0]}} & dat[idx][0]) |
                    ({DATA_W{way_hit[1]}} & dat[idx][1]);
  assign victim   = !vld[idx][0] ? 1'b0 : (!vld[idx][1] ? 1'b1 : lru[idx]);
  assign fill     = (state == S_FILL) && mem_ack;

  assign req_ready = (state == S_IDLE);
  assign mem_blk   = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_data  <= '0;
      mem_req    <= 1'b0;
      lru        <= '0;
      for (int s = 0; s < SETS; s++) vld[s] <= 2'b00;
    end else begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) state <= S_LOOK;
        S_LOOK: begin
          if (hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_data  <= hit_data;
            lru[idx]   <= ~way_hit[1];
            state      <= S_IDLE;
          end else begin
            mem_req <= 1'b1;
            state   <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          mem_req          <= 1'b0;
          vld[idx][victim] <= 1'b1;
          lru[idx]         <= ~victim;
          resp_valid       <= 1'b1;
          resp_miss        <= 1'b1;
          resp_data        <= mem_rdata;
          state            <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_IDLE && req_valid) cur <= req_blk;
    if (fill) begin
      tagm[idx][victim] <= tag;
      dat[idx][victim]  <= mem_rdata;
    end
  end

  assert_one_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit ^ resp_miss));
  assert_flags_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !(resp_hit || resp_miss));
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_fetch_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_blk)));
  assert_fetch_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  assert_ack_gives_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (resp_valid && resp_miss));
endmodule

// File: tb/cache2w_lru_test.sv
module cache2w_lru_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int SETS    = 2;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_blk = '0;
  logic req_ready, resp_valid, resp_hit, resp_miss, mem_req;
  logic [DATA_W-1:0] resp_data;
  logic [ADDR_W-1:0] mem_blk;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int mcnt = 0;
  bit in_hit_access = 0;
  int stray_req = 0;

  bit mv [SETS][2];
  int mt [SETS][2];
  bit ml [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache2w_lru #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_miss(resp_miss), .resp_data(resp_data), .mem_req(mem_req),
    .mem_blk(mem_blk), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  function automatic logic [DATA_W-1:0] word_of(int a);
    return 32'hA5C3_0000 ^ (32'(a) * 32'h0001_0101);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [ADDR_W-1:0] want_blk = '0;
  always @(negedge clk) begin
    if (mem_req && in_hit_access) stray_req++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      mcnt = 0;
    end else if (mem_req && rst_n) begin
      mcnt++;
      if (mcnt == MEM_LAT) begin
        check(mem_blk == want_blk, "R4 mem_blk", mem_blk, want_blk);
        mem_rdata = word_of(int'(mem_blk));
        mem_ack = 1'b1;
      end
    end
  end

  task automatic access(int a, string req, int exp_kind);
    int s, t, lat, w, exp_lat;
    bit h;
    s = a % SETS;
    t = a / SETS;
    h = 0; w = 0;
    for (int k = 0; k < 2; k++) if (mv[s][k] && mt[s][k] == t) begin h = 1; w = k; end
    if (exp_kind >= 0) check(h == exp_kind[0], {req, " model"}, h, exp_kind);
    while (!req_ready) @(negedge clk);
    want_blk = ADDR_W'(a);
    in_hit_access = h;
    stray_req = 0;
    req_blk = ADDR_W'(a);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    check(!req_ready, "R9 busy", req_ready, 0);
    while (!resp_valid) begin
      @(negedge clk);
      lat++;
    end
    exp_lat = h ? 2 : MEM_LAT + 2;
    check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    check(resp_hit == h && resp_miss == !h, {req, " hit/miss"}, {resp_hit, resp_miss}, {h, !h});
    check(resp_data == word_of(a), {req, " data"}, resp_data, word_of(a));
    if (h) check(stray_req == 0, "R3 no fetch on hit", stray_req, 0);
    in_hit_access = 0;
    if (!h) begin
      if (!mv[s][0]) w = 0;
      else if (!mv[s][1]) w = 1;
      else w = ml[s];
      mv[s][w] = 1;
      mt[s][w] = t;
    end
    ml[s] = ~w[0];
    @(negedge clk);
    check(!resp_valid, "R9 pulse", resp_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      mv[s][0] = 0; mv[s][1] = 0; ml[s] = 0;
    end
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R1 ready", req_ready, 1);
    check(resp_valid == 0, "R1 resp_valid", resp_valid, 0);
    check(mem_req == 0, "R1 mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    access(0, "R8 blk0", 0);
    access(8, "R8 blk8", 0);
    access(0, "R8 blk0 again", 1);
    access(6, "R8 blk6 evicts 8", 0);
    access(8, "R8 blk8 evicts 0", 0);
    access(6, "R8 blk6 resident", 1);
    access(0, "R7 blk0 was evicted", 0);

    access(1, "R2 odd set fill", 0);
    access(3, "R6 empty way filled", 0);
    access(1, "R5 both ways hit", 1);
    access(3, "R5 second way hit", 1);
    access(6, "R2 other set untouched", -1);
    access(5, "R7 evict lru 1", 0);
    access(3, "R7 recent kept", 1);
    access(1, "R7 lru gone", 0);

    for (int i = 0; i < 32; i++) access(i, "R1/R2 sweep", -1);
    begin
      logic [7:0] lf = 8'h5B;
      for (int i = 0; i < 600; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        access(i < 300 ? int'(lf) % 8 : int'(lf) % 32, "R3/R4/R7 random", -1);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule